// File: doc/BRIEF.md
# Chained Sharing-List Directory Manager

This block keeps coherence bookkeeping for a single memory block shared by up to `N` nodes. Sharers are tracked as a doubly linked chain rather than a presence bit vector. The memory side holds a cached/home flag and a head pointer. Every node entry holds a state plus forward and backward pointers. A new reader always becomes the head of the chain. Only the head may strip the chain down to itself.

Commands arrive one at a time, each naming a node and an operation: read-join, self-delete, purge or write. The block walks the pointer and state updates cycle by cycle until every entry is stable again. It then pulses a completion that carries the node's resulting state and, for a join, the former head. Data movement is reduced to a writeback strobe, which pulses whenever a dirty copy leaves the chain. A query port reads any node entry combinationally.

Top module: `share_chain_dir`

## Requirements
- R1: After reset every node reads state 0 (absent). Both pointers of every node read NULL, which is all ones. Memory reads home (`mem_cached`=0) with `mem_head` NULL. A node state is {lock[5], prop[4:2], pos[1:0]}. The pos codes are only=0, head=1, mid=2, tail=3. The prop codes are absent=0, pending=1, clean=2, dirty=3, busy=4.
- R2: Op codes are read=0, delete=1, purge=2, write=3. A read by an absent node while memory is home sets memory cached with head = requester. The requester becomes only|clean with NULL pointers, and `done_old_head` is NULL.
- R3: A read by an absent node while memory is cached inserts the requester as head|clean, with fwd = old head and bwd NULL, and moves memory's head to the requester. The old head turns only→tail or head→mid, keeps its prop, and gets bwd = requester. `done_old_head` returns the old head id.
- R4: A joining node reads prop pending in the cycle after its command is accepted.
- R5: Deleting a head, mid or tail node links around it. The predecessor's fwd takes the node's fwd, and the successor's bwd takes the node's bwd. A new first element turns mid→head or tail→only, and a new last element turns head→only or mid→tail. Memory's head follows a deleted head. The deleted node becomes absent with NULL pointers.
- R6: Deleting the only member returns memory to home. `wb_strobe` pulses exactly once for each dirty node that leaves the chain through a delete or a purge, and at no other time.
- R7: In the cycle after a delete is accepted, the deleting node and its existing neighbours read lock=1. No node is locked at completion.
- R8: A purge by the head or the only node reads prop busy in the cycle after acceptance. It removes one follower per cycle, and each removed follower becomes absent with NULL pointers. The purging node ends only|clean.
- R9: A write by an only node makes it only|dirty, with `done_valid` in the cycle after acceptance.
- R10: A write by a head, mid, tail or absent node ends with the writer only|dirty and the sole member, with every other node absent. A mid or tail writer first deletes itself, then rejoins as head and reports that head in `done_old_head`.
- R11: A read by a member, a delete by an absent node, and a purge by a node that is neither head nor only complete in the cycle after acceptance with no change to any entry or to memory, and with no writeback.
- R12: `cmd_ready` drops in the cycle after acceptance and stays low until the cycle after `done_valid`. Whenever it is high, no node is locked, pending or busy.
- R13: `done_valid` pulses for one cycle with `done_node` = the commanding node and `done_state` = that node's resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken this cycle |
| cmd_op | input | 2 | Operation code |
| cmd_node | input | IDW | Commanding node id |
| done_valid | output | 1 | Completion pulse |
| done_node | output | IDW | Node that issued the completed command |
| done_state | output | 6 | Resulting state of that node |
| done_old_head | output | PTR_W | Former head on a join, else NULL |
| wb_strobe | output | 1 | Writeback of a dirty copy |
| mem_cached | output | 1 | Memory state: 1 cached, 0 home |
| mem_head | output | PTR_W | Memory forward pointer to the head |
| qry_node | input | IDW | Node entry to read |
| qry_state | output | 6 | State of the queried node |
| qry_fwd | output | PTR_W | Forward pointer of the queried node |
| qry_bwd | output | PTR_W | Backward pointer of the queried node |

## Verification
The assertions assume that `cmd_node` names one of the `N` configured nodes and that `cmd_op`/`cmd_node` hold steady during the accepting cycle. They also rely on the chain having been built only through this block's own commands, so pointers never name a node outside the range. The bench drives only ids 0 to 7 on the default eight-node build. It raises `cmd_valid` only when `cmd_ready` is high and for a single cycle, which keeps every command inside those assumptions while a long op/node sweep reaches every chain position.

// File: rtl/share_chain_pkg.sv
package share_chain_pkg;

  typedef enum logic [1:0] {POS_ONLY, POS_HEAD, POS_MID, POS_TAIL} pos_e;
  typedef enum logic [2:0] {PR_ABSENT, PR_PEND, PR_CLEAN, PR_DIRTY, PR_BUSY} prop_e;
  typedef enum logic [1:0] {OP_READ, OP_DELETE, OP_PURGE, OP_WRITE} op_e;
  typedef enum logic [2:0] {PH_IDLE, PH_JOIN, PH_UNLINK, PH_PURGE, PH_FIN} phase_e;

  typedef struct packed {
    logic  lock;
    prop_e prop;
    pos_e  pos;
  } nstate_t;

  function automatic nstate_t mk_state(prop_e pr, pos_e ps);
    nstate_t s;
    s.lock = 1'b0;
    s.prop = pr;
    s.pos  = ps;
    return s;
  endfunction

  // position of the previous head once a new head is placed in front of it
  function automatic pos_e pos_behind_new_head(pos_e p);
    case (p)
      POS_ONLY: return POS_TAIL;
      POS_HEAD: return POS_MID;
      default:  return p;
    endcase
  endfunction

  // position once the element in front of this one disappears
  function automatic pos_e pos_front_gone(pos_e p);
    case (p)
      POS_MID:  return POS_HEAD;
      POS_TAIL: return POS_ONLY;
      default:  return p;
    endcase
  endfunction

  // position once the element behind this one disappears
  function automatic pos_e pos_back_gone(pos_e p);
    case (p)
      POS_HEAD: return POS_ONLY;
      POS_MID:  return POS_TAIL;
      default:  return p;
    endcase
  endfunction

endpackage

// File: rtl/share_chain_mem.sv
module share_chain_mem #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             cached_d,
  input  logic [PTR_W-1:0] head_d,
  output logic             cached_q,
  output logic [PTR_W-1:0] head_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cached_q <= 1'b0;
      head_q   <= '1;
    end else if (we) begin
      cached_q <= cached_d;
      head_q   <= head_d;
    end
  end
endmodule

// File: rtl/share_chain_nodes.sv
module share_chain_nodes import share_chain_pkg::*; #(
  parameter int N     = 8,
  parameter int PTR_W = 16,
  parameter int NWP   = 3,
  localparam int IDW  = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWP-1:0][IDW-1:0]   wp_idx,
  input  logic [NWP-1:0]            wp_st_en,
  input  nstate_t [NWP-1:0]         wp_st,
  input  logic [NWP-1:0]            wp_f_en,
  input  logic [NWP-1:0][PTR_W-1:0] wp_f,
  input  logic [NWP-1:0]            wp_b_en,
  input  logic [NWP-1:0][PTR_W-1:0] wp_b,
  output nstate_t [N-1:0]           st,
  output logic [N-1:0][PTR_W-1:0]   fwd,
  output logic [N-1:0][PTR_W-1:0]   bwd
);
  nstate_t          st_q  [N];
  logic [PTR_W-1:0] fwd_q [N];
  logic [PTR_W-1:0] bwd_q [N];

  for (genvar i = 0; i < N; i++) begin : g_node
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]  <= '0;
        fwd_q[i] <= '1;
        bwd_q[i] <= '1;
      end else begin
        for (int p = 0; p < NWP; p++) begin
          if (wp_idx[p] == IDW'(i)) begin
            if (wp_st_en[p]) st_q[i]  <= wp_st[p];
            if (wp_f_en[p])  fwd_q[i] <= wp_f[p];
            if (wp_b_en[p])  bwd_q[i] <= wp_b[p];
          end
        end
      end
    end
    assign st[i]  = st_q[i];
    assign fwd[i] = fwd_q[i];
    assign bwd[i] = bwd_q[i];
  end
endmodule

// File: rtl/share_chain_seq.sv
module share_chain_seq import share_chain_pkg::*; #(
  parameter int N     = 8,
  parameter int PTR_W = 16,
  localparam int IDW  = $clog2(N),
  localparam int NWP  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [IDW-1:0]            cmd_node,
  output logic                      cmd_ready,
  input  nstate_t [N-1:0]           st,
  input  logic [N-1:0][PTR_W-1:0]   fwd,
  input  logic [N-1:0][PTR_W-1:0]   bwd,
  input  logic                      mem_cached,
  input  logic [PTR_W-1:0]          mem_head,
  output logic [NWP-1:0][IDW-1:0]   wp_idx,
  output logic [NWP-1:0]            wp_st_en,
  output nstate_t [NWP-1:0]         wp_st,
  output logic [NWP-1:0]            wp_f_en,
  output logic [NWP-1:0][PTR_W-1:0] wp_f,
  output logic [NWP-1:0]            wp_b_en,
  output logic [NWP-1:0][PTR_W-1:0] wp_b,
  output logic                      mem_we,
  output logic                      mem_cached_d,
  output logic [PTR_W-1:0]          mem_head_d,
  output logic                      wb_strobe,
  output logic                      done_valid,
  output logic [IDW-1:0]            done_node,
  output logic [PTR_W-1:0]          done_old_head
);
  localparam logic [PTR_W-1:0] NULLP = '1;

  function automatic logic [IDW-1:0] p2i(logic [PTR_W-1:0] p);
    return p[IDW-1:0];
  endfunction
  function automatic logic [PTR_W-1:0] i2p(logic [IDW-1:0] i);
    return {{(PTR_W-IDW){1'b0}}, i};
  endfunction

  phase_e           phase_q, phase_d;
  logic [IDW-1:0]   node_q, node_d;
  logic             wr_q, wr_d;
  logic [PTR_W-1:0] oh_q, oh_d;

  // named views of the entry being worked on and its neighbours
  logic [IDW-1:0]   sel, pred_i, succ_i, head_i, third_i;
  nstate_t          me, pred_st, succ_st, head_st;
  logic [PTR_W-1:0] me_f, me_b, third_p;
  logic             pred_ok, succ_ok, third_ok, in_list, headish;
  logic             go_pend, go_lock, go_busy, go_dirty;

  always_comb begin
    sel      = (phase_q == PH_IDLE) ? cmd_node : node_q;
    me       = st[sel];
    me_f     = fwd[sel];
    me_b     = bwd[sel];
    pred_i   = p2i(me_b);
    succ_i   = p2i(me_f);
    pred_ok  = (me_b != NULLP);
    succ_ok  = (me_f != NULLP);
    pred_st  = st[pred_i];
    succ_st  = st[succ_i];
    third_p  = fwd[succ_i];
    third_i  = p2i(third_p);
    third_ok = (third_p != NULLP);
    head_i   = p2i(mem_head);
    head_st  = st[head_i];
    in_list  = (me.prop != PR_ABSENT);
    headish  = (me.pos == POS_ONLY) || (me.pos == POS_HEAD);
  end

  always_comb begin
    phase_d = phase_q;
    node_d  = node_q;
    wr_d    = wr_q;
    oh_d    = oh_q;
    wp_idx  = '0;
    wp_st_en = '0;
    wp_st   = '0;
    wp_f_en = '0;
    wp_f    = '1;
    wp_b_en = '0;
    wp_b    = '1;
    wp_idx[0] = sel;
    mem_we       = 1'b0;
    mem_cached_d = mem_cached;
    mem_head_d   = mem_head;
    wb_strobe    = 1'b0;
    go_pend  = 1'b0;
    go_lock  = 1'b0;
    go_busy  = 1'b0;
    go_dirty = 1'b0;

    case (phase_q)
      PH_IDLE: if (cmd_valid) begin
        node_d  = cmd_node;
        wr_d    = (op_e'(cmd_op) == OP_WRITE);
        oh_d    = NULLP;
        phase_d = PH_FIN;
        case (op_e'(cmd_op))
          OP_READ:   go_pend = !in_list;
          OP_DELETE: go_lock = in_list;
          OP_PURGE:  go_busy = in_list && headish;
          default: begin
            go_pend  = !in_list;
            go_dirty = in_list && (me.pos == POS_ONLY);
            go_busy  = in_list && (me.pos == POS_HEAD);
            go_lock  = in_list && !headish;
          end
        endcase
        if (go_pend) begin
          wp_st_en[0] = 1'b1;
          wp_st[0]    = mk_state(PR_PEND, POS_ONLY);
          phase_d     = PH_JOIN;
        end
        if (go_dirty) begin
          wp_st_en[0] = 1'b1;
          wp_st[0]    = mk_state(PR_DIRTY, POS_ONLY);
        end
        if (go_busy) begin
          wp_st_en[0] = 1'b1;
          wp_st[0]    = mk_state(PR_BUSY, me.pos);
          phase_d     = PH_PURGE;
        end
        if (go_lock) begin
          wp_st_en[0] = 1'b1;
          wp_st[0]    = me;
          wp_st[0].lock = 1'b1;
          wp_idx[1]   = pred_i;
          wp_st_en[1] = pred_ok;
          wp_st[1]    = pred_st;
          wp_st[1].lock = 1'b1;
          wp_idx[2]   = succ_i;
          wp_st_en[2] = succ_ok;
          wp_st[2]    = succ_st;
          wp_st[2].lock = 1'b1;
          wb_strobe   = (me.prop == PR_DIRTY);
          phase_d     = PH_UNLINK;
        end
      end

      PH_UNLINK: begin
        wp_st_en[0] = 1'b1;
        wp_st[0]    = wr_q ? mk_state(PR_PEND, POS_ONLY) : '0;
        wp_f_en[0]  = 1'b1;
        wp_b_en[0]  = 1'b1;
        wp_idx[1]   = pred_i;
        wp_st_en[1] = pred_ok;
        wp_st[1]    = mk_state(pred_st.prop,
                               succ_ok ? pred_st.pos : pos_back_gone(pred_st.pos));
        wp_f_en[1]  = pred_ok;
        wp_f[1]     = me_f;
        wp_idx[2]   = succ_i;
        wp_st_en[2] = succ_ok;
        wp_st[2]    = mk_state(succ_st.prop,
                               pred_ok ? succ_st.pos : pos_front_gone(succ_st.pos));
        wp_b_en[2]  = succ_ok;
        wp_b[2]     = me_b;
        if (!pred_ok) begin
          mem_we       = 1'b1;
          mem_cached_d = succ_ok;
          mem_head_d   = me_f;
        end
        phase_d = wr_q ? PH_JOIN : PH_FIN;
      end

      PH_JOIN: begin
        wp_st_en[0]  = 1'b1;
        wp_f_en[0]   = 1'b1;
        wp_b_en[0]   = 1'b1;
        mem_we       = 1'b1;
        mem_cached_d = 1'b1;
        mem_head_d   = i2p(sel);
        if (!mem_cached) begin
          wp_st[0] = mk_state(wr_q ? PR_DIRTY : PR_CLEAN, POS_ONLY);
          phase_d  = PH_FIN;
        end else begin
          wp_st[0]    = mk_state(wr_q ? PR_BUSY : PR_CLEAN, POS_HEAD);
          wp_f[0]     = mem_head;
          wp_idx[1]   = head_i;
          wp_st_en[1] = 1'b1;
          wp_st[1]    = mk_state(head_st.prop, pos_behind_new_head(head_st.pos));
          wp_b_en[1]  = 1'b1;
          wp_b[1]     = i2p(sel);
          oh_d        = mem_head;
          phase_d     = wr_q ? PH_PURGE : PH_FIN;
        end
      end

      PH_PURGE: begin
        if (succ_ok) begin
          wp_f_en[0]  = 1'b1;
          wp_f[0]     = third_p;
          wp_idx[1]   = succ_i;
          wp_st_en[1] = 1'b1;
          wp_f_en[1]  = 1'b1;
          wp_b_en[1]  = 1'b1;
          wb_strobe   = (succ_st.prop == PR_DIRTY);
          wp_idx[2]   = third_i;
          wp_b_en[2]  = third_ok;
          wp_b[2]     = i2p(sel);
        end else begin
          wp_st_en[0] = 1'b1;
          wp_st[0]    = mk_state(wr_q ? PR_DIRTY : PR_CLEAN, POS_ONLY);
          wp_f_en[0]  = 1'b1;
          wp_b_en[0]  = 1'b1;
          phase_d     = PH_FIN;
        end
      end

      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      node_q  <= '0;
      wr_q    <= 1'b0;
      oh_q    <= '1;
    end else begin
      phase_q <= phase_d;
      node_q  <= node_d;
      wr_q    <= wr_d;
      oh_q    <= oh_d;
    end
  end

  assign cmd_ready     = (phase_q == PH_IDLE);
  assign done_valid    = (phase_q == PH_FIN);
  assign done_node     = node_q;
  assign done_old_head = oh_q;
endmodule

// File: rtl/share_chain_dir.sv
module share_chain_dir import share_chain_pkg::*; #(
  parameter int N     = 8,
  parameter int PTR_W = 16,
  localparam int IDW  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [IDW-1:0]   cmd_node,
  output logic             done_valid,
  output logic [IDW-1:0]   done_node,
  output logic [5:0]       done_state,
  output logic [PTR_W-1:0] done_old_head,
  output logic             wb_strobe,
  output logic             mem_cached,
  output logic [PTR_W-1:0] mem_head,
  input  logic [IDW-1:0]   qry_node,
  output logic [5:0]       qry_state,
  output logic [PTR_W-1:0] qry_fwd,
  output logic [PTR_W-1:0] qry_bwd
);
  localparam int NWP = 3;

  nstate_t [N-1:0]           node_st;
  logic [N-1:0][PTR_W-1:0]   node_fwd;
  logic [N-1:0][PTR_W-1:0]   node_bwd;
  logic [NWP-1:0][IDW-1:0]   wp_idx;
  logic [NWP-1:0]            wp_st_en, wp_f_en, wp_b_en;
  nstate_t [NWP-1:0]         wp_st;
  logic [NWP-1:0][PTR_W-1:0] wp_f, wp_b;
  logic                      mem_we, mem_cached_d;
  logic [PTR_W-1:0]          mem_head_d;
  logic                      qry_ok;

  share_chain_seq #(.N(N), .PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node), .cmd_ready(cmd_ready),
    .st(node_st), .fwd(node_fwd), .bwd(node_bwd),
    .mem_cached(mem_cached), .mem_head(mem_head),
    .wp_idx(wp_idx), .wp_st_en(wp_st_en), .wp_st(wp_st),
    .wp_f_en(wp_f_en), .wp_f(wp_f), .wp_b_en(wp_b_en), .wp_b(wp_b),
    .mem_we(mem_we), .mem_cached_d(mem_cached_d), .mem_head_d(mem_head_d),
    .wb_strobe(wb_strobe), .done_valid(done_valid), .done_node(done_node),
    .done_old_head(done_old_head)
  );

  share_chain_nodes #(.N(N), .PTR_W(PTR_W), .NWP(NWP)) u_nodes (
    .clk(clk), .rst_n(rst_n),
    .wp_idx(wp_idx), .wp_st_en(wp_st_en), .wp_st(wp_st),
    .wp_f_en(wp_f_en), .wp_f(wp_f), .wp_b_en(wp_b_en), .wp_b(wp_b),
    .st(node_st), .fwd(node_fwd), .bwd(node_bwd)
  );

  share_chain_mem #(.PTR_W(PTR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we),
    .cached_d(mem_cached_d), .head_d(mem_head_d),
    .cached_q(mem_cached), .head_q(mem_head)
  );

  assign done_state = node_st[done_node];
  assign qry_ok     = (int'(qry_node) < N);
  assign qry_state  = qry_ok ? node_st[qry_node]  : '0;
  assign qry_fwd    = qry_ok ? node_fwd[qry_node] : '1;
  assign qry_bwd    = qry_ok ? node_bwd[qry_node] : '1;
endmodule

// File: rtl/share_chain_dir_chk.sv
module share_chain_dir_chk import share_chain_pkg::*; #(
  parameter int N     = 8,
  parameter int PTR_W = 16,
  localparam int IDW  = $clog2(N)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic                    done_valid,
  input logic                    wb_strobe,
  input logic                    mem_cached,
  input logic [PTR_W-1:0]        mem_head,
  input nstate_t [N-1:0]         node_st,
  input logic [N-1:0][PTR_W-1:0] node_bwd
);
  localparam logic [PTR_W-1:0] NULLP = '1;

  logic    all_stable;
  nstate_t hd;
  always_comb begin
    all_stable = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (node_st[i].lock || node_st[i].prop == PR_PEND || node_st[i].prop == PR_BUSY)
        all_stable = 1'b0;
    end
    hd = node_st[mem_head[IDW-1:0]];
  end

  assert_home_null_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cached |-> mem_head == NULLP);

  assert_accept_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_stable_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> all_stable);

  assert_done_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> cmd_ready);

  assert_wb_in_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> (!cmd_ready || cmd_valid));

  assert_head_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && mem_cached) |->
      (node_bwd[mem_head[IDW-1:0]] == NULLP &&
       (hd.pos == POS_ONLY || hd.pos == POS_HEAD) && hd.prop != PR_ABSENT));
endmodule

bind share_chain_dir share_chain_dir_chk #(.N(N), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done_valid(done_valid), .wb_strobe(wb_strobe), .mem_cached(mem_cached),
  .mem_head(mem_head), .node_st(node_st), .node_bwd(node_bwd)
);

// File: tb/share_chain_dir_tb.sv
module share_chain_dir_tb;
  localparam int N = 8;
  localparam int PTR_W = 16;
  localparam logic [PTR_W-1:0] NULLP = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_node = 3'd0;
  logic [2:0] qry_node = 3'd0;
  logic cmd_ready, done_valid, wb_strobe, mem_cached;
  logic [2:0] done_node;
  logic [5:0] done_state, qry_state;
  logic [PTR_W-1:0] done_old_head, mem_head, qry_fwd, qry_bwd;

  always #10 clk = ~clk;

  share_chain_dir #(.N(N), .PTR_W(PTR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_node(cmd_node), .done_valid(done_valid),
    .done_node(done_node), .done_state(done_state), .done_old_head(done_old_head),
    .wb_strobe(wb_strobe), .mem_cached(mem_cached), .mem_head(mem_head),
    .qry_node(qry_node), .qry_state(qry_state), .qry_fwd(qry_fwd), .qry_bwd(qry_bwd)
  );

  int checks = 0;
  int fails = 0;
  int wb_cnt = 0;
  int cycles = 0;

  int lst [N];
  int len = 0;
  bit dirty [N];

  always @(posedge clk) if (rst_n && wb_strobe) wb_cnt++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int find(int n);
    for (int k = 0; k < len; k++) if (lst[k] == n) return k;
    return -1;
  endfunction

  function automatic void remove(int n);
    int p;
    p = find(n);
    for (int k = p; k < len - 1; k++) lst[k] = lst[k+1];
    len--;
  endfunction

  function automatic void push_front(int n);
    for (int k = len; k > 0; k--) lst[k] = lst[k-1];
    lst[0] = n;
    len++;
  endfunction

  function automatic int purge_others(int n);
    int w;
    w = 0;
    for (int k = 0; k < len; k++) if (lst[k] != n) begin
      w += int'(dirty[lst[k]]);
      dirty[lst[k]] = 1'b0;
    end
    lst[0] = n;
    len = 1;
    return w;
  endfunction

  // expected state {lock, prop[2:0], pos[1:0]}: pos only0 head1 mid2 tail3, prop clean2 dirty3
  function automatic logic [5:0] exp_state(int n);
    int i;
    logic [1:0] ps;
    logic [2:0] pr;
    i = find(n);
    if (i < 0) return 6'd0;
    ps = (len == 1) ? 2'd0 : (i == 0) ? 2'd1 : (i == len - 1) ? 2'd3 : 2'd2;
    pr = dirty[n] ? 3'd3 : 3'd2;
    return {1'b0, pr, ps};
  endfunction

  function automatic logic [PTR_W-1:0] exp_fwd(int n);
    int i;
    i = find(n);
    if (i < 0 || i == len - 1) return NULLP;
    return PTR_W'(lst[i+1]);
  endfunction

  function automatic logic [PTR_W-1:0] exp_bwd(int n);
    int i;
    i = find(n);
    if (i <= 0) return NULLP;
    return PTR_W'(lst[i-1]);
  endfunction

  task automatic look(input int k);
    qry_node = 3'(k);
    #1;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < N; k++) begin
      look(k);
      chk(req, $sformatf("node %0d state", k), 32'(qry_state), 32'(exp_state(k)));
      chk(req, $sformatf("node %0d fwd", k), 32'(qry_fwd), 32'(exp_fwd(k)));
      chk(req, $sformatf("node %0d bwd", k), 32'(qry_bwd), 32'(exp_bwd(k)));
    end
    chk(req, "mem cached", 32'(mem_cached), 32'(len > 0));
    chk(req, "mem head", 32'(mem_head), (len > 0) ? 32'(lst[0]) : 32'(NULLP));
  endtask

  // op: 0 read, 1 delete, 2 purge, 3 write
  task automatic run(input int op, input int n, input string req);
    int i, pr, su, exp_wb, w0, g;
    logic [PTR_W-1:0] exp_old;
    bit pend, busy, lockk, quick;
    i  = find(n);
    pr = (i > 0) ? lst[i-1] : -1;
    su = (i >= 0 && i < len - 1) ? lst[i+1] : -1;
    pend  = (op == 0 || op == 3) && i < 0;
    busy  = (op == 2 && i == 0) || (op == 3 && i == 0 && len > 1);
    lockk = (op == 1 && i >= 0) || (op == 3 && i > 0);
    quick = !(pend || busy || lockk);
    exp_old = NULLP;
    exp_wb  = 0;
    case (op)
      0: if (i < 0) begin
        if (len > 0) exp_old = PTR_W'(lst[0]);
        push_front(n);
        dirty[n] = 1'b0;
      end
      1: if (i >= 0) begin
        exp_wb += int'(dirty[n]);
        remove(n);
        dirty[n] = 1'b0;
      end
      2: if (i == 0) begin
        exp_wb += purge_others(n);
        dirty[n] = 1'b0;
      end
      default: begin
        if (i == 0 && len == 1) dirty[n] = 1'b1;
        else begin
          if (i > 0) begin
            exp_wb += int'(dirty[n]);
            remove(n);
            dirty[n] = 1'b0;
          end
          if (i != 0) begin
            if (len > 0) exp_old = PTR_W'(lst[0]);
            push_front(n);
            dirty[n] = 1'b0;
          end
          exp_wb += purge_others(n);
          dirty[n] = 1'b1;
        end
      end
    endcase

    while (!cmd_ready) @(negedge clk);
    w0 = wb_cnt;
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_node  = 3'(n);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12", "ready after accept", 32'(cmd_ready), 32'd0);
    if (pend) begin
      look(n);
      chk("R4", "pending state", 32'(qry_state), 32'h04);
    end
    if (busy) begin
      look(n);
      chk("R8", "busy prop", 32'(qry_state[4:2]), 32'd4);
    end
    if (lockk) begin
      look(n);
      chk("R7", "self lock", 32'(qry_state[5]), 32'd1);
      if (pr >= 0) begin
        look(pr);
        chk("R7", "pred lock", 32'(qry_state[5]), 32'd1);
      end
      if (su >= 0) begin
        look(su);
        chk("R7", "succ lock", 32'(qry_state[5]), 32'd1);
      end
    end
    if (quick) chk((op == 3) ? "R9" : "R11", "done next cycle", 32'(done_valid), 32'd1);
    g = 0;
    while (!done_valid && g < 200) begin
      @(negedge clk);
      g++;
    end
    chk("R13", "done pulse", 32'(done_valid), 32'd1);
    chk("R13", "done node", 32'(done_node), 32'(n));
    chk("R13", "done state", 32'(done_state), 32'(exp_state(n)));
    chk((op == 3) ? "R10" : "R3", "old head", 32'(done_old_head), 32'(exp_old));
    chk("R6", "writebacks", 32'(wb_cnt - w0), 32'(exp_wb));
    check_all(req);
    @(negedge clk);
    chk("R12", "ready after done", 32'(cmd_ready), 32'd1);
    chk("R13", "done single pulse", 32'(done_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    int op, nd;
    for (int k = 0; k < N; k++) dirty[k] = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    chk("R1", "ready out of reset", 32'(cmd_ready), 32'd1);

    run(0, 3, "R2");
    run(0, 5, "R3");
    run(0, 1, "R3");
    run(1, 5, "R5");
    run(0, 5, "R3");
    run(0, 6, "R3");
    run(1, 6, "R5");
    run(1, 3, "R5");
    run(2, 1, "R11");
    run(0, 5, "R11");
    run(1, 7, "R11");
    run(2, 5, "R8");
    run(3, 5, "R9");
    run(0, 2, "R3");
    run(1, 5, "R6");
    run(3, 2, "R9");
    run(1, 2, "R6");
    for (int k = 0; k < N; k++) run(0, k, "R3");
    run(3, 4, "R10");
    run(0, 1, "R3");
    run(0, 6, "R3");
    run(3, 4, "R10");
    run(0, 0, "R3");
    run(3, 7, "R10");
    run(0, 3, "R3");
    run(3, 3, "R10");
    run(2, 3, "R8");
    run(1, 3, "R6");

    x = 32'h1234_5678;
    for (int it = 0; it < 700; it++) begin
      x  = x * 32'd1103515245 + 32'd12345;
      op = int'(x[17:16]);
      nd = int'(x[22:20]);
      if (op == 1 && x[25]) op = 0;
      case (op)
        0: run(op, nd, "R3");
        1: run(op, nd, "R5");
        2: run(op, nd, "R8");
        default: run(op, nd, "R10");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule